// File: doc/BRIEF.md
# Line-Doubling Scan Converter

This block turns an interlaced field stream into a progressive stream by showing every incoming line twice. One clock runs at the output pixel rate. An input enable is high on every second cycle, so input samples arrive at exactly half the output rate. Each input line is stored in one half of a two-bank line memory. It is then replayed twice from that half while the next line fills the other half. The replay rate is one pixel per clock, which doubles both the pixel rate and the line rate.

An input line begins with a horizontal sync sample. At that sample the stored length of the line just ended is captured, the banks swap and an output sync is issued. The block also measures the input line period in clocks. Half of that period after each input-driven output sync, it issues a second output sync and starts the second replay. The result is an output sync at twice the input line rate. Samples with the valid flag low are not stored, so gaps inside a line close up on the output. A line longer than the bank depth is cut at the depth.

Top module: `scan_doubler`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` and `out_hsync` are low.
- R2: The input pins are sampled only in cycles where `in_en` is high. Values present on `in_valid`, `in_hsync` or the pixel inputs while `in_en` is low store nothing and start no line.
- R3: A sampled input sync (`in_en` and `in_hsync` high at a clock edge) makes `out_hsync` high for exactly the following cycle, and the first replay of the line just ended begins.
- R4: A second `out_hsync` pulse comes exactly P/2 clocks (rounded down) after the first. P is the number of clocks between the two most recent sampled input syncs. After the first sampled sync following reset, no second pulse is issued.
- R5: After each `out_hsync` pulse, the stored pixels of the previous input line appear in arrival order on `{out_y,out_cr,out_cb}`, one per cycle with `out_valid` high. The first pixel appears in the cycle after the pulse, and the run is exactly as long as the stored line.
- R6: The line being written goes to the bank opposite the one being replayed, so incoming pixels never alter either replay of the previous line.
- R7: A sample taken with `in_valid` high and `in_hsync` low is stored. A sample with `in_valid` low is dropped, and the stored line is the valid samples with no gaps. A sync sample stores no pixel.
- R8: The stored length of a line is min(valid samples, DEPTH). It is captured at the line's closing sync. A line with no valid samples replays with no `out_valid` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Input sample strobe, high every second cycle |
| in_valid | input | 1 | Input sample carries a pixel |
| in_hsync | input | 1 | Input sample is a line start |
| in_y | input | DATA_W | Input luma |
| in_cr | input | DATA_W | Input red-difference chroma |
| in_cb | input | DATA_W | Input blue-difference chroma |
| out_valid | output | 1 | Output pixel is valid |
| out_hsync | output | 1 | Doubled-rate line sync pulse |
| out_y | output | DATA_W | Output luma |
| out_cr | output | DATA_W | Output red-difference chroma |
| out_cb | output | DATA_W | Output blue-difference chroma |

## Verification
The bench builds the block with DEPTH = 16, DATA_W = 8 and CNT_W = 12. The shallow bank lets lines that overflow it, lines that fill it exactly and empty lines all occur within a few dozen samples each. The input line length varies from line to line between 28 and 34 samples. This shows that the second sync follows the measured period of each line rather than a fixed value. Garbage driven on the off-strobe cycles, including false syncs and false valid flags, tests that those cycles are ignored.

// File: rtl/sd_pkg.sv
package sd_pkg;

    // colour components carried per pixel
    localparam int unsigned SD_CHANNELS = 3;

    // which half of the line memory a pointer refers to
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } sd_bank_e;

endpackage

// File: rtl/sd_line_ram.sv
// Simple dual-port memory: one write port, one read port, read data
// registered (one clock of read latency).
module sd_line_ram #(
    parameter int unsigned WIDTH  = 24,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/sd_line_timer.sv
// Measures the input line period in clocks and flags the midpoint of the
// following line, where the second replay starts.
module sd_line_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic replay2
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic             seen;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        replay2 = 1'b0;
        if (line_start) begin
            // cnt_q equals the clocks elapsed since the previous line start
            tmr_d.cnt  = CNT_ONE;
            tmr_d.half = tmr_q.seen ? (tmr_q.cnt >> 1) : '0;
            tmr_d.seen = 1'b1;
        end else begin
            if (tmr_q.cnt != CNT_MAX) begin
                tmr_d.cnt = tmr_q.cnt + CNT_ONE;
            end
            replay2 = (tmr_q.half != '0) && (tmr_q.cnt == tmr_q.half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/scan_doubler.sv
module scan_doubler
    import sd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic              in_valid,
    input  logic              in_hsync,
    input  logic [DATA_W-1:0] in_y,
    input  logic [DATA_W-1:0] in_cr,
    input  logic [DATA_W-1:0] in_cb,
    output logic              out_valid,
    output logic              out_hsync,
    output logic [DATA_W-1:0] out_y,
    output logic [DATA_W-1:0] out_cr,
    output logic [DATA_W-1:0] out_cb
);

    localparam int unsigned PIX_W  = SD_CHANNELS * DATA_W;
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned PTR_W  = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        sd_bank_e         wr_bank;
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] rd_len;
        sd_bank_e         rd_bank;
        logic             out_valid;
        logic             out_hsync;
    } state_t;

    state_t st_d, st_q;

    logic             line_start;
    logic             store;
    logic             rd_go;
    logic             replay2;
    logic [PIX_W-1:0] rd_pix;

    assign line_start = in_en & in_hsync;
    assign store      = in_en & in_valid & ~in_hsync & (st_q.wr_ptr < PTR_FULL);
    assign rd_go      = st_q.rd_ptr < st_q.rd_len;

    sd_line_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .replay2    (replay2)
    );

    sd_line_ram #(
        .WIDTH  (PIX_W),
        .ADDR_W (ADDR_W + 1)
    ) ram_i (
        .clk   (clk),
        .we    (store),
        .waddr ({st_q.wr_bank, st_q.wr_ptr[ADDR_W-1:0]}),
        .wdata ({in_y, in_cr, in_cb}),
        .raddr ({st_q.rd_bank, st_q.rd_ptr[ADDR_W-1:0]}),
        .rdata (rd_pix)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = rd_go;     // data for this read leaves the RAM next cycle
        st_d.out_hsync = 1'b0;

        if (rd_go) begin
            st_d.rd_ptr = st_q.rd_ptr + PTR_ONE;
        end
        if (store) begin
            st_d.wr_ptr = st_q.wr_ptr + PTR_ONE;
        end

        if (line_start) begin
            // close the line: freeze its length, swap banks, first replay
            st_d.rd_len    = st_q.wr_ptr;
            st_d.rd_bank   = st_q.wr_bank;
            st_d.wr_bank   = (st_q.wr_bank == BANK_A) ? BANK_B : BANK_A;
            st_d.wr_ptr    = '0;
            st_d.rd_ptr    = '0;
            st_d.out_hsync = 1'b1;
        end else if (replay2) begin
            // midpoint of the line: second replay of the same bank
            st_d.rd_ptr    = '0;
            st_d.out_hsync = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rd_bank <= BANK_B;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_hsync = st_q.out_hsync;
    assign {out_y, out_cr, out_cb} = rd_pix;

endmodule

// File: rtl/scan_doubler_chk.sv
module scan_doubler_chk #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_en,
    input logic             in_hsync,
    input logic             out_hsync,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] rd_len,
    input logic             wr_bank,
    input logic             rd_bank
);

    // R8: the stored length never passes the bank depth
    assert_wr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PTR_W'(DEPTH));

    // R5: a replay never reads past the captured line length
    assert_rd_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= rd_len);

    // R3: every output sync coincides with a restarted replay
    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_hsync |-> (rd_ptr == '0));

    // R3: a sampled input sync yields an output sync one clock later
    assert_sync_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && in_hsync) |=> out_hsync);

    // R2: without the strobe the write side does not move
    assert_en_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> ($stable(wr_ptr) && $stable(wr_bank)));

    // R6: the replayed bank is never the bank being written
    assert_bank_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bank != wr_bank);

endmodule

bind scan_doubler scan_doubler_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_en     (in_en),
    .in_hsync  (in_hsync),
    .out_hsync (out_hsync),
    .wr_ptr    (st_q.wr_ptr),
    .rd_ptr    (st_q.rd_ptr),
    .rd_len    (st_q.rd_len),
    .wr_bank   (st_q.wr_bank),
    .rd_bank   (st_q.rd_bank)
);

// File: tb/scan_doubler_tb_top.sv
`timescale 1ns/1ps
module scan_doubler_tb_top;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          in_en, in_valid, in_hsync;
    logic [DW-1:0] in_y, in_cr, in_cb;
    logic          out_valid, out_hsync;
    logic [DW-1:0] out_y, out_cr, out_cb;

    scan_doubler #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_valid(in_valid),
        .in_hsync(in_hsync), .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
        .out_valid(out_valid), .out_hsync(out_hsync),
        .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // driver-side record of the line being sent and the line staged for replay
    logic [23:0] cur_pix [64];
    int          cur_cnt = 0;
    int          cur_n   = 0;
    bit          seen_hs = 1'b0;
    logic [23:0] stg_pix [64];
    int          stg_len = 0;
    int          first_exp  = -1;
    int          second_exp = -1;

    // monitor-side copy
    logic [23:0] mon_pix [64];
    int          mon_len = 0;
    int          idx     = 0;
    bit          mon_hs  = 1'b0;

    function automatic int stored_len(int n);
        return (n > DEPTH) ? DEPTH : n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one input sample: strobe cycle, then an off cycle carrying garbage (R2)
    task automatic sample(bit v, bit h, logic [23:0] p);
        @(negedge clk);
        in_en = 1'b1; in_valid = v; in_hsync = h;
        {in_y, in_cr, in_cb} = p;
        if (h) begin
            stg_len = stored_len(cur_cnt);
            for (int i = 0; i < stg_len; i++) stg_pix[i] = cur_pix[i];
            first_exp  = cyc + 1;
            second_exp = seen_hs ? cyc + 1 + cur_n : -1;
            seen_hs = 1'b1;
            cur_cnt = 0;
            cur_n   = 1;
        end else begin
            cur_n++;
            if (v) begin
                if (cur_cnt < 64) cur_pix[cur_cnt] = p;
                cur_cnt++;
            end
        end
        @(negedge clk);
        in_en    = 1'b0;
        in_valid = 1'($urandom);
        in_hsync = 1'($urandom);
        {in_y, in_cr, in_cb} = 24'($urandom);
    endtask

    // a line of exactly n_tot samples with nv valid pixels
    task automatic send_line(int nv, int n_tot, int gap_pct);
        int used = 1;
        sample(1'b0, 1'b1, 24'($urandom));
        for (int k = 0; k < nv; k++) begin
            while ((used < n_tot - 1 - (nv - k)) && ($urandom_range(99) < gap_pct)) begin
                sample(1'b0, 1'b0, 24'($urandom));
                used++;
            end
            sample(1'b1, 1'b0, 24'($urandom));
            used++;
        end
        while (used < n_tot) begin
            sample(1'b0, 1'b0, 24'($urandom));
            used++;
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (mon_on) begin
            bit exp_hs;
            exp_hs = (cyc == first_exp) || (cyc == second_exp);
            if (out_hsync || exp_hs) begin
                if (cyc == second_exp)
                    check(out_hsync == exp_hs, "R4 second sync timing", out_hsync, exp_hs);
                else
                    check(out_hsync == exp_hs, "R3 first sync timing", out_hsync, exp_hs);
            end
            if (out_hsync) begin
                if (mon_hs) check(idx == mon_len, "R5 R8 replay length", idx, mon_len);
                if (cyc == first_exp) begin
                    mon_len = stg_len;
                    for (int i = 0; i < mon_len; i++) mon_pix[i] = stg_pix[i];
                end
                idx    = 0;
                mon_hs = 1'b1;
            end else if (out_valid) begin
                if (idx < mon_len)
                    check({out_y, out_cr, out_cb} == mon_pix[idx], "R5 R6 R7 pixel data",
                          int'({out_y, out_cr, out_cb}), int'(mon_pix[idx]));
                else
                    check(1'b0, "R8 pixel beyond stored length", idx, mon_len);
                idx++;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_en = 1'b0; in_valid = 1'b0; in_hsync = 1'b0;
        {in_y, in_cr, in_cb} = '0;
        repeat (4) @(negedge clk);
        check(!out_valid && !out_hsync, "R1 outputs in reset", {out_valid, out_hsync}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_hsync, "R1 outputs after reset", {out_valid, out_hsync}, 0);
        mon_on = 1'b1;

        // R2: strobe low with sync and valid high must do nothing
        for (int i = 0; i < 20; i++) begin
            in_en = 1'b0; in_hsync = 1'b1; in_valid = 1'b1;
            {in_y, in_cr, in_cb} = 24'($urandom);
            @(negedge clk);
            check(!out_hsync && !out_valid, "R2 no sync without strobe", {out_valid, out_hsync}, 0);
        end
        in_hsync = 1'b0; in_valid = 1'b0;

        send_line(8, 30, 0);            // first line: single replay sync (R4)
        send_line(0, 30, 0);            // replays 8 pixels, then an empty line (R8)
        send_line(DEPTH + 5, 32, 0);    // overflow (R8)
        send_line(DEPTH, 30, 0);        // exactly full
        send_line(6, 34, 60);           // gapped pixels (R7)
        send_line(3, 28, 0);
        for (int l = 0; l < 30; l++) begin
            send_line($urandom_range(0, DEPTH + 3), $urandom_range(28, 34), $urandom_range(0, 40));
        end
        send_line(0, 30, 0);
        send_line(0, 30, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule